// File: doc/BRIEF.md
# Card Data Byte FIFO Engine

This block carries the data phase of a card transfer between a processor register port and a byte-wide card data path. Two 32-entry byte FIFOs decouple the two sides. The receive FIFO fills from the card and drains through processor reads. The transmit FIFO fills through processor writes and drains toward the card. A single processor access moves one, two or four bytes at once.

When the data phase starts, the engine loads a remaining-byte count equal to the block count times the block length. It then moves one byte per accepted card handshake until the count reaches zero. The engine raises a service request whenever the processor must empty the receive FIFO or refill the transmit FIFO. At the end of a transfer it sets completion flags for the command controller and the interrupt router. An abort input ends a transfer early, for example when the card clock stops or the command setup is rewritten. A flush input discards transmit bytes that were queued and never sent.

Top module: `card_byte_fifo_engine`

## Requirements
- R1: A pulse on `start_i` loads the remaining count with `nblk_i * blen_i` (16-bit by 12-bit), latches the direction, sets the engine active, and clears both FIFOs, both requests and both completion flags. A zero product completes on the next clock.
- R2: In write direction, `card_tx_valid_o` is high only while the engine is active, bytes remain and the transmit FIFO is non-empty, and `card_tx_data_o` is the oldest queued byte. Each accepted byte (valid and ready on the same clock edge) lowers the count by one. `tx_req_o` is set while the engine is active in write direction, bytes remain and the transmit FIFO is empty.
- R3: In read direction, `card_rx_ready_o` is high only while the engine is active, bytes remain and the receive FIFO holds fewer than 32 bytes. Each accepted byte is stored in the FIFO, lowers the count and sets `rx_req_o`.
- R4: The processor size code on `cpu_size_i` selects N bytes: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 gives 4 bytes. A push takes the first byte from lane N-1 (bits 8N-1..8N-8) and continues down to lane 0. A pop places the first byte in lane N-1 and continues downward. Lanes at and above N are zero, and so are lanes for which the FIFO had no byte. `cpu_rdata_o` is updated on the clock edge that performs the pop and holds its value until the next pop.
- R5: A push clears `tx_req_o`. A pop clears `rx_req_o` unless a card byte is accepted on the same edge. Bytes pushed into a full FIFO are dropped.
- R6: A pulse on `flush_i` empties the transmit FIFO. Bytes pushed afterwards are the next ones sent.
- R7: When the remaining count is zero while the engine is active, the engine goes inactive on the next edge and sets `data_done_o`. For a write transfer it also sets `prog_done_o`. Both flags hold until the next start.
- R8: A pulse on `abort_i` makes the engine inactive on the next edge without setting the completion flags. Abort takes priority over start.
- R9: After reset the engine is inactive, all flags and requests are low, both FIFOs are empty and `cpu_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the data phase |
| abort_i | input | 1 | Abort the transfer in progress |
| write_i | input | 1 | Direction sampled at start: 1 sends to the card, 0 receives |
| nblk_i | input | 16 | Block count |
| blen_i | input | 12 | Block length in bytes |
| cpu_size_i | input | 2 | Access size code (see R4) |
| cpu_tx_push_i | input | 1 | Processor write to the transmit FIFO |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rx_pop_i | input | 1 | Processor read of the receive FIFO |
| cpu_rdata_o | output | 32 | Read data from the last pop |
| flush_i | input | 1 | Discard the transmit FIFO contents |
| card_tx_valid_o | output | 1 | Byte offered to the card |
| card_tx_data_o | output | 8 | Byte toward the card |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| card_rx_valid_i | input | 1 | Byte offered by the card |
| card_rx_data_i | input | 8 | Byte from the card |
| card_rx_ready_o | output | 1 | Engine accepts the byte |
| active_o | output | 1 | Transfer in progress |
| tx_req_o | output | 1 | Transmit FIFO needs refilling |
| rx_req_o | output | 1 | Receive FIFO holds data |
| data_done_o | output | 1 | Transfer completed |
| prog_done_o | output | 1 | Write transfer completed |

## Verification
Card-side strobes are combinational from state, so they are checked in the same cycle. Byte handshakes complete on the next edge. Requests, counts, completion flags and `cpu_rdata_o` change one edge after their cause, and completion lags the last accepted byte by one further edge. The bench drives inputs 1 ns after a rising edge and samples on the falling edge. It judges every card-bound byte against a scoreboard queue that is filled when the processor pushes. Where the outcome depends on the engine having made progress, such as completion or draining, the bench waits a fixed number of clock cycles comfortably beyond the latency before it samples.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  localparam int CPU_LANES = 4;

  typedef enum logic [1:0] {
    SZ_1B  = 2'd0,
    SZ_2B  = 2'd1,
    SZ_4B  = 2'd2,
    SZ_4BX = 2'd3
  } cpu_size_e;

  function automatic logic [2:0] size_nbytes(input logic [1:0] sz);
    case (cpu_size_e'(sz))
      SZ_1B:   size_nbytes = 3'd1;
      SZ_2B:   size_nbytes = 3'd2;
      default: size_nbytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cbf_byte_fifo.sv
module cbf_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  flush_i,
  input  logic [NW-1:0]         push_req_i,
  input  logic [LANES-1:0][7:0] push_data_i,
  input  logic [NW-1:0]         pop_req_i,
  output logic [LANES-1:0][7:0] head_o,
  output logic [CW-1:0]         count_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q, free, push_w, pop_w, push_take, pop_take;
  logic          hold;

  assign hold   = clear_i | flush_i;
  assign push_w = CW'(push_req_i);
  assign pop_w  = CW'(pop_req_i);
  assign free   = CW'(DEPTH) - count_q;

  always_comb begin
    push_take = (push_w > free) ? free : push_w;
    pop_take  = (pop_w > count_q) ? count_q : pop_w;
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LANES; i++) begin
      if (!hold && (CW'(i) < push_take)) mem[wr_ptr + PW'(i)] <= push_data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      // drop contents and move to the other half of the ring
      rd_ptr  <= rd_ptr + PW'(DEPTH / 2);
      wr_ptr  <= rd_ptr + PW'(DEPTH / 2);
      count_q <= '0;
    end else begin
      wr_ptr  <= wr_ptr + PW'(push_take);
      rd_ptr  <= rd_ptr + PW'(pop_take);
      count_q <= count_q + push_take - pop_take;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) head_o[i] = mem[rd_ptr + PW'(i)];
  end

  assign count_o = count_q;
endmodule

// File: rtl/cbf_lane_pack.sv
module cbf_lane_pack
  import cbf_pkg::*;
#(
  parameter int CW = 6,
  localparam int LANES = CPU_LANES,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic [1:0]            size_i,
  input  logic [8*LANES-1:0]    wdata_i,
  input  logic [LANES-1:0][7:0] head_i,
  input  logic [CW-1:0]         avail_i,
  output logic [NW-1:0]         n_o,
  output logic [LANES-1:0][7:0] wbytes_o,
  output logic [8*LANES-1:0]    rdata_o
);
  int n;

  assign n_o = NW'(size_nbytes(size_i));
  assign n   = int'(n_o);

  always_comb begin
    wbytes_o = '0;
    rdata_o  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) begin
        wbytes_o[i] = wdata_i[8*(n-1-i) +: 8];
        if (i < int'(avail_i)) rdata_o[8*(n-1-i) +: 8] = head_i[i];
      end
    end
  end
endmodule

// File: rtl/cbf_xfer_ctrl.sv
module cbf_xfer_ctrl #(
  parameter int NBLK_W = 16,
  parameter int BLEN_W = 12,
  localparam int LEFT_W = NBLK_W + BLEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              write_i,
  input  logic [NBLK_W-1:0] nblk_i,
  input  logic [BLEN_W-1:0] blen_i,
  input  logic              beat_i,
  input  logic              rx_beat_i,
  input  logic              rx_pop_i,
  input  logic              tx_push_i,
  input  logic              tx_empty_i,
  output logic              active_o,
  output logic              dir_wr_o,
  output logic [LEFT_W-1:0] left_o,
  output logic              tx_req_o,
  output logic              rx_req_o,
  output logic              data_done_o,
  output logic              prog_done_o
);
  logic              active_q, dir_q, tx_req_q, rx_req_q, dd_q, pd_q;
  logic [LEFT_W-1:0] left_q;
  logic              left_nz;

  assign left_nz = |left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      left_q   <= '0;
      dd_q     <= 1'b0;
      pd_q     <= 1'b0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      dir_q    <= write_i;
      left_q   <= LEFT_W'(nblk_i) * LEFT_W'(blen_i);
      dd_q     <= 1'b0;
      pd_q     <= 1'b0;
    end else if (active_q) begin
      if (!left_nz) begin
        active_q <= 1'b0;
        dd_q     <= 1'b1;
        pd_q     <= dir_q;
      end else if (beat_i) begin
        left_q <= left_q - LEFT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_req_q <= 1'b0;
      rx_req_q <= 1'b0;
    end else if (start_i && !abort_i) begin
      tx_req_q <= 1'b0;
      rx_req_q <= 1'b0;
    end else begin
      if (tx_push_i) tx_req_q <= 1'b0;
      else if (active_q && dir_q && left_nz && tx_empty_i) tx_req_q <= 1'b1;
      if (rx_beat_i) rx_req_q <= 1'b1;
      else if (rx_pop_i) rx_req_q <= 1'b0;
    end
  end

  assign active_o    = active_q;
  assign dir_wr_o    = dir_q;
  assign left_o      = left_q;
  assign tx_req_o    = tx_req_q;
  assign rx_req_o    = rx_req_q;
  assign data_done_o = dd_q;
  assign prog_done_o = pd_q;
endmodule

// File: rtl/card_byte_fifo_engine.sv
module card_byte_fifo_engine
  import cbf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NBLK_W = 16,
  parameter int BLEN_W = 12,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = PW + 1,
  localparam int NW     = $clog2(CPU_LANES + 1),
  localparam int DW     = 8 * CPU_LANES,
  localparam int LEFT_W = NBLK_W + BLEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              write_i,
  input  logic [NBLK_W-1:0] nblk_i,
  input  logic [BLEN_W-1:0] blen_i,
  input  logic [1:0]        cpu_size_i,
  input  logic              cpu_tx_push_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  input  logic              cpu_rx_pop_i,
  output logic [DW-1:0]     cpu_rdata_o,
  input  logic              flush_i,
  output logic              card_tx_valid_o,
  output logic [7:0]        card_tx_data_o,
  input  logic              card_tx_ready_i,
  input  logic              card_rx_valid_i,
  input  logic [7:0]        card_rx_data_i,
  output logic              card_rx_ready_o,
  output logic              active_o,
  output logic              tx_req_o,
  output logic              rx_req_o,
  output logic              data_done_o,
  output logic              prog_done_o
);
  logic [CW-1:0]               tx_count, rx_count;
  logic [CPU_LANES-1:0][7:0]   tx_head, rx_head, wbytes, rx_push_bytes;
  logic [NW-1:0]               acc_n, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [DW-1:0]               rdata_next, rdata_q;
  logic [LEFT_W-1:0]           bytes_left;
  logic                        dir_wr, left_nz, tx_hs, rx_hs, clear;

  assign clear   = start_i & ~abort_i;
  assign left_nz = |bytes_left;

  assign card_tx_valid_o = active_o & dir_wr & left_nz & (tx_count != '0);
  assign card_tx_data_o  = tx_head[0];
  assign card_rx_ready_o = active_o & ~dir_wr & left_nz & (rx_count < CW'(DEPTH));

  assign tx_hs = card_tx_valid_o & card_tx_ready_i;
  assign rx_hs = card_rx_ready_o & card_rx_valid_i;

  assign tx_push_n = cpu_tx_push_i ? acc_n : '0;
  assign tx_pop_n  = tx_hs ? NW'(1) : '0;
  assign rx_push_n = rx_hs ? NW'(1) : '0;
  assign rx_pop_n  = cpu_rx_pop_i ? acc_n : '0;

  always_comb begin
    rx_push_bytes    = '0;
    rx_push_bytes[0] = card_rx_data_i;
  end

  cbf_lane_pack #(.CW(CW)) u_pack (
    .size_i  (cpu_size_i),
    .wdata_i (cpu_wdata_i),
    .head_i  (rx_head),
    .avail_i (rx_count),
    .n_o     (acc_n),
    .wbytes_o(wbytes),
    .rdata_o (rdata_next)
  );

  cbf_byte_fifo #(.DEPTH(DEPTH), .LANES(CPU_LANES)) u_tx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .flush_i    (flush_i),
    .push_req_i (tx_push_n),
    .push_data_i(wbytes),
    .pop_req_i  (tx_pop_n),
    .head_o     (tx_head),
    .count_o    (tx_count)
  );

  cbf_byte_fifo #(.DEPTH(DEPTH), .LANES(CPU_LANES)) u_rx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .flush_i    (1'b0),
    .push_req_i (rx_push_n),
    .push_data_i(rx_push_bytes),
    .pop_req_i  (rx_pop_n),
    .head_o     (rx_head),
    .count_o    (rx_count)
  );

  cbf_xfer_ctrl #(.NBLK_W(NBLK_W), .BLEN_W(BLEN_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .write_i    (write_i),
    .nblk_i     (nblk_i),
    .blen_i     (blen_i),
    .beat_i     (tx_hs | rx_hs),
    .rx_beat_i  (rx_hs),
    .rx_pop_i   (cpu_rx_pop_i),
    .tx_push_i  (cpu_tx_push_i),
    .tx_empty_i (tx_count == '0),
    .active_o   (active_o),
    .dir_wr_o   (dir_wr),
    .left_o     (bytes_left),
    .tx_req_o   (tx_req_o),
    .rx_req_o   (rx_req_o),
    .data_done_o(data_done_o),
    .prog_done_o(prog_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cpu_rx_pop_i) rdata_q <= rdata_next;
  end

  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/cbf_checker.sv
module cbf_checker #(
  parameter int DEPTH  = 32,
  parameter int CW     = 6,
  parameter int LEFT_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              abort_i,
  input logic              cpu_tx_push_i,
  input logic              cpu_rx_pop_i,
  input logic              card_tx_valid_o,
  input logic              card_tx_ready_i,
  input logic              card_rx_valid_i,
  input logic              card_rx_ready_o,
  input logic              active_o,
  input logic              tx_req_o,
  input logic              data_done_o,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic [LEFT_W-1:0] bytes_left
);
  logic beat;
  assign beat = (card_tx_valid_o && card_tx_ready_i) || (card_rx_valid_i && card_rx_ready_o);

  p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && bytes_left != '0 && beat && !abort_i && !start_i)
      |=> bytes_left == $past(bytes_left) - LEFT_W'(1));

  p_tx_has_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_tx_valid_o |-> (active_o && tx_count != '0));

  p_rx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CW'(DEPTH));

  p_rx_grow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_rx_valid_i && card_rx_ready_o && !start_i && !cpu_rx_pop_i)
      |=> rx_count == $past(rx_count) + CW'(1));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count <= CW'(DEPTH));

  p_tx_req_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_tx_push_i |=> !tx_req_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_done_o) |-> !active_o);

  p_abort_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !active_o);
endmodule

bind card_byte_fifo_engine cbf_checker #(.DEPTH(DEPTH), .CW(CW), .LEFT_W(LEFT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .abort_i        (abort_i),
  .cpu_tx_push_i  (cpu_tx_push_i),
  .cpu_rx_pop_i   (cpu_rx_pop_i),
  .card_tx_valid_o(card_tx_valid_o),
  .card_tx_ready_i(card_tx_ready_i),
  .card_rx_valid_i(card_rx_valid_i),
  .card_rx_ready_o(card_rx_ready_o),
  .active_o       (active_o),
  .tx_req_o       (tx_req_o),
  .data_done_o    (data_done_o),
  .tx_count       (tx_count),
  .rx_count       (rx_count),
  .bytes_left     (bytes_left)
);

// File: tb/card_byte_fifo_engine_tb_top.sv
`timescale 1ns/1ps
module card_byte_fifo_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0, write_i = 1'b0;
  logic [15:0] nblk_i = '0;
  logic [11:0] blen_i = '0;
  logic [1:0]  cpu_size_i = '0;
  logic        cpu_tx_push_i = 1'b0, cpu_rx_pop_i = 1'b0, flush_i = 1'b0;
  logic [31:0] cpu_wdata_i = '0;
  logic [31:0] cpu_rdata_o;
  logic        card_tx_valid_o, card_rx_ready_o;
  logic [7:0]  card_tx_data_o;
  logic        card_tx_ready_i = 1'b0;
  logic        card_rx_valid_i = 1'b0;
  logic [7:0]  card_rx_data_i = '0;
  logic        active_o, tx_req_o, rx_req_o, data_done_o, prog_done_o;

  int n_chk = 0, n_fail = 0, tx_seen = 0;
  logic [7:0] exp_q[$];
  int   rx_left = 0;
  logic [7:0] rx_val = '0;
  logic rx_took = 1'b0;

  always #4 clk_i = ~clk_i;

  card_byte_fifo_engine dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for bytes leaving toward the card
  always @(negedge clk_i) begin
    if (rst_ni && card_tx_valid_o && card_tx_ready_i) begin
      n_chk++;
      tx_seen++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected byte: actual %h expected none", card_tx_data_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (card_tx_data_o !== e) begin
          n_fail++;
          $display("FAIL R2 byte order: actual %h expected %h", card_tx_data_o, e);
        end
      end
    end
  end

  // card byte source
  always @(negedge clk_i) rx_took = card_rx_valid_i && card_rx_ready_o;
  always @(posedge clk_i) begin
    #1;
    if (rx_took) begin
      rx_val  = rx_val + 8'd1;
      rx_left = rx_left - 1;
    end
    card_rx_valid_i = (rx_left != 0);
    card_rx_data_i  = rx_val;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic start_xfer(input logic wr, input logic [15:0] nb, input logic [11:0] bl);
    write_i = wr; nblk_i = nb; blen_i = bl; start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic cpu_push(input logic [1:0] sz, input logic [31:0] d, input int keep);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int i = 0; i < keep && i < n; i++) exp_q.push_back(d[8*(n-1-i) +: 8]);
    cpu_size_i = sz; cpu_wdata_i = d; cpu_tx_push_i = 1'b1;
    tick(1);
    cpu_tx_push_i = 1'b0;
  endtask

  task automatic cpu_pop(input logic [1:0] sz, input logic [31:0] exp, input string tag);
    cpu_size_i = sz; cpu_rx_pop_i = 1'b1;
    tick(1);
    cpu_rx_pop_i = 1'b0;
    check(tag, cpu_rdata_o, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seen0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R9 reset state
    check("R9 active", active_o, 0);
    check("R9 flags", {data_done_o, prog_done_o, tx_req_o, rx_req_o}, 0);
    check("R9 strobes", {card_tx_valid_o, card_rx_ready_o}, 0);
    check("R9 rdata", cpu_rdata_o, 0);

    // R1/R2/R4/R7 write of 1x6 bytes
    card_tx_ready_i = 1'b1;
    start_xfer(1'b1, 16'd1, 12'd6);
    tick(2);
    check("R2 tx_req when empty", tx_req_o, 1);
    check("R2 no valid when empty", card_tx_valid_o, 0);
    cpu_push(2'd2, 32'hA1B2C3D4, 4);
    check("R5 push clears tx_req", tx_req_o, 0);
    cpu_push(2'd1, 32'h1234E5F6, 2);
    tick(10);
    check("R1 six bytes sent", tx_seen, 6);
    check("R7 write done", {active_o, data_done_o, prog_done_o}, 3'b011);
    check("R2 queue drained", exp_q.size(), 0);

    // R3/R4/R7 read of 2x3 bytes
    start_xfer(1'b0, 16'd2, 12'd3);
    check("R7 flags cleared on start", {data_done_o, prog_done_o}, 0);
    @(negedge clk_i);
    rx_val = 8'h10; rx_left = 6;
    tick(15);
    check("R3 rx_req", rx_req_o, 1);
    check("R7 read done", {active_o, data_done_o, prog_done_o}, 3'b010);
    cpu_pop(2'd2, 32'h10111213, "R4 pop 4");
    check("R5 pop clears rx_req", rx_req_o, 0);
    cpu_pop(2'd0, 32'h00000014, "R4 pop 1");
    cpu_pop(2'd3, 32'h15000000, "R4 pop short zero lanes");
    cpu_pop(2'd1, 32'h00000000, "R4 pop empty");

    // R3 receive FIFO full stalls the card
    start_xfer(1'b0, 16'd1, 12'd40);
    @(negedge clk_i);
    rx_val = 8'h40; rx_left = 40;
    tick(45);
    check("R3 ready low when full", card_rx_ready_o, 0);
    check("R3 still active", active_o, 1);
    for (int k = 0; k < 10; k++) begin
      logic [7:0] b;
      b = 8'h40 + 8'(4 * k);
      cpu_pop(2'd2, {b, b + 8'd1, b + 8'd2, b + 8'd3}, "R3 stream order");
      tick(3);
    end
    check("R7 long read done", data_done_o, 1);

    // R5 transmit overflow drop
    card_tx_ready_i = 1'b0;
    start_xfer(1'b1, 16'd1, 12'd40);
    for (int k = 0; k < 9; k++) begin
      logic [7:0] b;
      b = 8'h80 + 8'(4 * k);
      cpu_push(2'd2, {b, b + 8'd1, b + 8'd2, b + 8'd3}, (k < 8) ? 4 : 0);
    end
    check("R2 valid with data", card_tx_valid_o, 1);
    seen0 = tx_seen;
    card_tx_ready_i = 1'b1;
    tick(40);
    check("R5 only 32 kept", tx_seen - seen0, 32);
    check("R2 tx_req after drain", {card_tx_valid_o, tx_req_o, active_o}, 3'b011);
    abort_i = 1'b1;
    tick(1);
    abort_i = 1'b0;
    check("R8 abort", {active_o, data_done_o}, 2'b00);

    // R6 flush
    card_tx_ready_i = 1'b0;
    start_xfer(1'b1, 16'd1, 12'd3);
    cpu_push(2'd2, 32'h11223344, 0);
    flush_i = 1'b1;
    tick(1);
    flush_i = 1'b0;
    check("R6 flushed empty", card_tx_valid_o, 0);
    cpu_push(2'd0, 32'hFFFFFF55, 1);
    cpu_push(2'd1, 32'hFFFF6677, 2);
    seen0 = tx_seen;
    card_tx_ready_i = 1'b1;
    tick(10);
    check("R6 new bytes sent", tx_seen - seen0, 3);
    check("R7 flush xfer done", {data_done_o, prog_done_o}, 2'b11);

    // R1 zero length
    start_xfer(1'b1, 16'd0, 12'd5);
    check("R1 zero start active", {active_o, data_done_o}, 2'b10);
    tick(1);
    check("R1 zero length done", {active_o, data_done_o}, 2'b01);

    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule